// File: doc/BRIEF.md
# I2C Mode and Status Register

This block holds the eight-bit mode and status register of an I2C bus interface. The CPU writes the master/slave and transmit/receive mode bits, and the block changes the register by itself in response to single-cycle event strobes from the bus engine. Those strobes report START, STOP, lost arbitration, a finished byte, a missing acknowledge, an address match, a general call, the received R/W bit and the last received data bit. The block drives the mode bits, the status flags, the read-back value and an active-high interrupt request.

The block also guards START generation. If the local side asks for a START while another master already holds the bus, or in the same cycle that a START is seen on the bus, the request is suppressed. The START strobe, the bit-counter clear and the SCL drive enable stay low, and both mode bits clear. The block has no streaming data path, so every pin is a plain control or status level or pulse. There is no valid/ready handshake and no back-pressure.

The register bit layout is fixed:

| Bit | Name | Meaning |
|-----|------|---------|
| 7 | mst | 1 = master |
| 6 | trx | 1 = transmit |
| 5 | busy | 1 = bus busy |
| 4 | irq_n | active low; 0 = request pending |
| 3 | arb | arbitration lost |
| 2 | adr | slave address matched |
| 1 | gcall | general call seen |
| 0 | lrb | last received bit |

Top module: `i2c_mode_status`

## Requirements
- R1: A synchronous active-high reset makes `rd_data` read 8'h10 on the following cycle. Every flag reads 0 except irq_n (bit 4), which reads 1, and `irq` is 0.
- R2: Bits 7:6 form the mode field with mst in bit 7 and trx in bit 6. The encodings are 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit. A CPU write with no clearing event in the same cycle loads them from `wr_data[7:6]` one cycle later.
- R3: While mst is 0 and `addr_mode` is 0, an address-match strobe loads trx from `ev_rw_bit` on the next cycle. While `addr_mode` is 1, the strobe leaves trx unchanged.
- R4: Any of the following clears trx on the next cycle: lost arbitration, STOP, a suppressed local START, a START seen while mst is 0, or a missing acknowledge while mst is 0. A START or a missing acknowledge seen while mst is 1 leaves trx unchanged.
- R5: STOP or a suppressed local START clears mst on the next cycle. A hardware clear of mst or trx wins over a CPU write in the same cycle.
- R6: After arbitration is lost, mst stays 1 until the byte-complete strobe and reads 0 on the cycle after that strobe.
- R7: A `start_req` asserted while busy is 1, or in the same cycle as `ev_start`, is suppressed. In that cycle `start_go`, `bitcnt_clr` and `scl_en` are all 0. Otherwise `start_go` and `bitcnt_clr` follow `start_req`, and `scl_en` equals mst.
- R8: busy (bit 5) sets on `ev_start` and clears on `ev_stop`, and START wins when both arrive in the same cycle. CPU writes to bit 5 are ignored.
- R9: irq_n (bit 4) goes to 0 after a byte-complete strobe, and `irq` goes to 1. A CPU write with `wr_data[4]` = 1 returns irq_n to 1, but a byte-complete strobe in the same cycle wins.
- R10: arb (bit 3) sets on lost arbitration and clears on the next START. adr (bit 2) sets on address match and gcall (bit 1) sets on general call, and both clear on START or STOP. A set wins over a clear in the same cycle.
- R11: lrb (bit 0) captures `ev_last_bit` on each byte-complete strobe.
- R12: CPU writes to bits 3:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read-back value |
| addr_mode | input | 1 | Address-mode select; 0 enables loading trx from the R/W bit |
| start_req | input | 1 | Local request to generate a START |
| ev_start | input | 1 | START detected on the bus |
| ev_stop | input | 1 | STOP detected on the bus |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_byte_done | input | 1 | Byte transfer complete |
| ev_nack | input | 1 | Acknowledge not returned |
| ev_addr_match | input | 1 | Slave address matched |
| ev_gen_call | input | 1 | General call detected |
| ev_rw_bit | input | 1 | Received R/W bit, valid with `ev_addr_match` |
| ev_last_bit | input | 1 | Last received bit, valid with `ev_byte_done` |
| mode_mst | output | 1 | Master mode bit |
| mode_trx | output | 1 | Transmit mode bit |
| irq | output | 1 | Interrupt request, active high |
| start_go | output | 1 | Permitted START generation strobe |
| bitcnt_clr | output | 1 | Permitted bit-counter clear |
| scl_en | output | 1 | SCL drive enable |

## Verification
The mode bits are first driven by CPU writes alone. They are then hit by each clearing event taken singly, in both master and slave mode, so that events that depend on mode are told apart from events that always clear. A CPU write is placed in the same cycle as STOP, and a CPU clear of irq_n in the same cycle as byte-complete, to show which source has priority. The arbitration sequence holds an idle cycle between the loss and the byte end, which separates a deferred clear of mst from an immediate one. The START guard is tried with the bus idle, with the bus already busy, and with a START arriving in the same cycle.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int REG_W = 8;
  localparam int B_MST = 7;
  localparam int B_TRX = 6;
  localparam int B_BUSY = 5;
  localparam int B_IRQN = 4;
  localparam int B_ARB = 3;
  localparam int B_ADR = 2;
  localparam int B_GCALL = 1;
  localparam int B_LRB = 0;
  localparam logic [REG_W-1:0] RST_VAL = 8'h10;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } mode_e;
endpackage

// File: rtl/i2c_start_guard.sv
module i2c_start_guard (
  input  logic start_req,
  input  logic bus_busy,
  input  logic ev_start,
  input  logic mst,
  output logic suppress,
  output logic start_go,
  output logic bitcnt_clr,
  output logic scl_en
);
  // Another master owns the bus, or is taking it right now
  logic foreign_owner;

  always_comb begin
    foreign_owner = bus_busy | ev_start;
    suppress      = start_req & foreign_owner;
    start_go      = start_req & ~foreign_owner;
    bitcnt_clr    = start_req & ~foreign_owner;
    scl_en        = mst & ~suppress;
  end
endmodule

// File: rtl/i2c_mode_bits.sv
module i2c_mode_bits
  import i2c_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  logic  wr_mst,
  input  logic  wr_trx,
  input  logic  addr_mode,
  input  logic  ev_start,
  input  logic  ev_stop,
  input  logic  ev_arb_lost,
  input  logic  ev_byte_done,
  input  logic  ev_nack,
  input  logic  ev_addr_match,
  input  logic  ev_rw_bit,
  input  logic  suppress,
  output mode_e mode
);
  logic mst_q, trx_q, al_pend_q;
  logic trx_clr, mst_clr, slv_load;

  always_comb begin
    trx_clr  = ev_arb_lost | ev_stop | suppress | ((ev_start | ev_nack) & ~mst_q);
    // Lost arbitration drops master mode only when the byte ends
    mst_clr  = ev_stop | suppress | ((al_pend_q | ev_arb_lost) & ev_byte_done);
    slv_load = ~mst_q & ~addr_mode & ev_addr_match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_q     <= 1'b0;
      trx_q     <= 1'b0;
      al_pend_q <= 1'b0;
    end else begin
      if (mst_clr)    mst_q <= 1'b0;
      else if (wr_en) mst_q <= wr_mst;

      if (trx_clr)       trx_q <= 1'b0;
      else if (slv_load) trx_q <= ev_rw_bit;
      else if (wr_en)    trx_q <= wr_trx;

      if (ev_stop | ev_byte_done) al_pend_q <= 1'b0;
      else if (ev_arb_lost)       al_pend_q <= 1'b1;
    end
  end

  assign mode = mode_e'({mst_q, trx_q});
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags #(
  parameter int N_STICKY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_irqn,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic ev_arb_lost,
  input  logic ev_byte_done,
  input  logic ev_addr_match,
  input  logic ev_gen_call,
  input  logic ev_last_bit,
  output logic busy,
  output logic irq_n,
  output logic arb,
  output logic [N_STICKY-1:0] sticky,
  output logic lrb
);
  logic [N_STICKY-1:0] sticky_set;

  assign sticky_set = N_STICKY'({ev_gen_call, ev_addr_match});

  // Flags set by one event, cleared on START or STOP; set wins
  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)                     sticky[i] <= 1'b0;
      else if (sticky_set[i])      sticky[i] <= 1'b1;
      else if (ev_start | ev_stop) sticky[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      irq_n <= 1'b1;
      arb   <= 1'b0;
      lrb   <= 1'b0;
    end else begin
      if (ev_start)     busy <= 1'b1;
      else if (ev_stop) busy <= 1'b0;

      if (ev_byte_done)            irq_n <= 1'b0;
      else if (wr_en && wr_irqn)   irq_n <= 1'b1;

      if (ev_arb_lost)   arb <= 1'b1;
      else if (ev_start) arb <= 1'b0;

      if (ev_byte_done) lrb <= ev_last_bit;
    end
  end
endmodule

// File: rtl/i2c_mode_status.sv
module i2c_mode_status
  import i2c_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             addr_mode,
  input  logic             start_req,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_arb_lost,
  input  logic             ev_byte_done,
  input  logic             ev_nack,
  input  logic             ev_addr_match,
  input  logic             ev_gen_call,
  input  logic             ev_rw_bit,
  input  logic             ev_last_bit,
  output logic             mode_mst,
  output logic             mode_trx,
  output logic             irq,
  output logic             start_go,
  output logic             bitcnt_clr,
  output logic             scl_en
);
  localparam int N_STICKY = 2;

  mode_e               mode;
  logic                suppress, busy, irq_n, arb, lrb;
  logic [N_STICKY-1:0] sticky;
  logic                unused_wr;

  assign unused_wr = ^{wr_data[B_BUSY], wr_data[B_ARB:B_LRB]};

  i2c_start_guard u_guard (
    .start_req (start_req),
    .bus_busy  (busy),
    .ev_start  (ev_start),
    .mst       (mode_mst),
    .suppress  (suppress),
    .start_go  (start_go),
    .bitcnt_clr(bitcnt_clr),
    .scl_en    (scl_en)
  );

  i2c_mode_bits u_mode (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_mst       (wr_data[B_MST]),
    .wr_trx       (wr_data[B_TRX]),
    .addr_mode    (addr_mode),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .ev_arb_lost  (ev_arb_lost),
    .ev_byte_done (ev_byte_done),
    .ev_nack      (ev_nack),
    .ev_addr_match(ev_addr_match),
    .ev_rw_bit    (ev_rw_bit),
    .suppress     (suppress),
    .mode         (mode)
  );

  i2c_status_flags #(.N_STICKY(N_STICKY)) u_flags (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_irqn      (wr_data[B_IRQN]),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .ev_arb_lost  (ev_arb_lost),
    .ev_byte_done (ev_byte_done),
    .ev_addr_match(ev_addr_match),
    .ev_gen_call  (ev_gen_call),
    .ev_last_bit  (ev_last_bit),
    .busy         (busy),
    .irq_n        (irq_n),
    .arb          (arb),
    .sticky       (sticky),
    .lrb          (lrb)
  );

  assign mode_mst = mode[1];
  assign mode_trx = mode[0];
  assign irq      = ~irq_n;
  assign rd_data  = {mode_mst, mode_trx, busy, irq_n, arb, sticky[0], sticky[1], lrb};
endmodule

// File: rtl/i2c_mode_status_chk.sv
module i2c_mode_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       addr_mode,
  input logic       start_req,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_arb_lost,
  input logic       ev_byte_done,
  input logic       ev_nack,
  input logic       ev_addr_match,
  input logic       ev_gen_call,
  input logic       ev_rw_bit,
  input logic       ev_last_bit,
  input logic       irq,
  input logic       start_go,
  input logic       bitcnt_clr,
  input logic       scl_en
);
  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h10 && !irq)); // R1

  AST_SLAVE_TRX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[7] && !addr_mode && ev_addr_match && !ev_arb_lost && !ev_stop &&
     !ev_start && !ev_nack && !start_req) |=> (rd_data[6] == $past(ev_rw_bit))); // R3

  AST_ARB_CLEARS_TRX: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |=> !rd_data[6]); // R4

  AST_STOP_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (rd_data[7:6] == 2'b00)); // R5

  AST_ARB_DEFERS_MST: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && ev_arb_lost && !ev_byte_done && !ev_stop && !start_req && !wr_en)
      |=> rd_data[7]); // R6

  AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (start_req && (rd_data[5] || ev_start)) |-> (!start_go && !bitcnt_clr && !scl_en)); // R7

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> rd_data[5]); // R8

  AST_BYTE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    ev_byte_done |=> (!rd_data[4] && irq)); // R9

  AST_GCALL_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_gen_call |=> rd_data[1]); // R10

  AST_LRB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ev_byte_done |=> (rd_data[0] == $past(ev_last_bit))); // R11

  AST_LOW_FLAGS_RO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ev_start && !ev_stop && !ev_arb_lost && !ev_byte_done &&
     !ev_addr_match && !ev_gen_call) |=> $stable(rd_data[3:0])); // R12
endmodule

bind i2c_mode_status i2c_mode_status_chk u_chk (.*);

// File: tb/i2c_mode_status_tb.sv
`timescale 1ns/1ps
module i2c_mode_status_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       addr_mode = 1'b0, start_req = 1'b0;
  logic       ev_start = 1'b0, ev_stop = 1'b0, ev_arb_lost = 1'b0, ev_byte_done = 1'b0;
  logic       ev_nack = 1'b0, ev_addr_match = 1'b0, ev_gen_call = 1'b0;
  logic       ev_rw_bit = 1'b0, ev_last_bit = 1'b0;
  logic       mode_mst, mode_trx, irq, start_go, bitcnt_clr, scl_en;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  i2c_mode_status u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    wr_en = 1'b0; start_req = 1'b0;
    ev_start = 1'b0; ev_stop = 1'b0; ev_arb_lost = 1'b0; ev_byte_done = 1'b0;
    ev_nack = 1'b0; ev_addr_match = 1'b0; ev_gen_call = 1'b0;
    ev_rw_bit = 1'b0; ev_last_bit = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_all();
  endtask

  task automatic cpu_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset value", rd_data, 8'h10);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_mode_write();
    cpu_wr(8'hFF);
    chk("R2 master transmit, R8 R12 bits ignored", rd_data, 8'hD0);
    cpu_wr(8'h9F);
    chk("R2 master receive", rd_data, 8'h90);
    chk("R2 mode pins", {6'd0, mode_mst, mode_trx}, 8'h02);
    cpu_wr(8'h10);
    chk("R2 slave receive", rd_data, 8'h10);
  endtask

  task automatic t_slave_load();
    ev_addr_match = 1'b1; ev_rw_bit = 1'b1; tick();
    chk("R3 trx loads 1, R10 adr set", rd_data, 8'h54);
    ev_start = 1'b1; tick();
    chk("R4 start in slave clears trx, R10 adr clears", rd_data, 8'h30);
    ev_addr_match = 1'b1; ev_rw_bit = 1'b0; tick();
    chk("R3 trx loads 0", rd_data, 8'h34);
    cpu_wr(8'h50);
    chk("R2 write trx", rd_data, 8'h74);
    addr_mode = 1'b1;
    ev_addr_match = 1'b1; ev_rw_bit = 1'b0; tick();
    chk("R3 addr_mode 1 keeps trx", rd_data, 8'h74);
    addr_mode = 1'b0;
    ev_stop = 1'b1; tick();
    chk("R5 stop clears", rd_data, 8'h10);
  endtask

  task automatic t_arb_sequence();
    cpu_wr(8'h40);
    ev_nack = 1'b1; tick();
    chk("R4 nack in slave clears trx", rd_data, 8'h10);
    cpu_wr(8'hC0);
    ev_nack = 1'b1; tick();
    chk("R4 nack in master keeps trx", rd_data, 8'hD0);
    ev_start = 1'b1; tick();
    chk("R4 start in master keeps trx, R8 busy", rd_data, 8'hF0);
    ev_arb_lost = 1'b1; tick();
    chk("R4 arb clears trx, R10 arb set", rd_data, 8'hB8);
    tick();
    chk("R6 mst held until byte end", rd_data, 8'hB8);
    ev_byte_done = 1'b1; ev_last_bit = 1'b1; tick();
    chk("R6 mst clears after byte, R9 R11", rd_data, 8'h29);
    chk("R9 irq high", {7'd0, irq}, 8'h01);
    cpu_wr(8'h10);
    chk("R9 cpu clears request", rd_data, 8'h39);
    ev_start = 1'b1; tick();
    chk("R10 start clears arb", rd_data, 8'h31);
    ev_stop = 1'b1; tick();
    chk("R8 stop clears busy", rd_data, 8'h11);
    ev_byte_done = 1'b1; ev_last_bit = 1'b0; tick();
    chk("R11 lrb captures 0", rd_data, 8'h00);
    cpu_wr(8'h10);
    chk("R9 request cleared", rd_data, 8'h10);
  endtask

  task automatic t_stop_priority();
    ev_start = 1'b1; tick();
    cpu_wr(8'hC0);
    chk("R2 master transmit on busy bus", rd_data, 8'hF0);
    ev_stop = 1'b1; tick();
    chk("R5 stop clears mode", rd_data, 8'h10);
    ev_start = 1'b1; tick();
    wr_en = 1'b1; wr_data = 8'hC0; ev_stop = 1'b1; tick();
    chk("R5 stop beats cpu write", rd_data, 8'h10);
  endtask

  task automatic t_guard();
    ev_start = 1'b1; tick();
    cpu_wr(8'hC0);
    start_req = 1'b1; #1;
    chk("R7 busy blocks start", {5'd0, start_go, bitcnt_clr, scl_en}, 8'h00);
    tick();
    chk("R5 suppressed start clears mode", rd_data, 8'h30);
    ev_stop = 1'b1; tick();
    cpu_wr(8'hC0);
    start_req = 1'b1; #1;
    chk("R7 idle bus allows start", {5'd0, start_go, bitcnt_clr, scl_en}, 8'h07);
    tick();
    chk("R7 allowed start keeps mode", rd_data, 8'hD0);
    start_req = 1'b1; ev_start = 1'b1; #1;
    chk("R7 coincident start blocks", {5'd0, start_go, bitcnt_clr, scl_en}, 8'h00);
    tick();
    chk("R4 R5 coincident suppression clears", rd_data, 8'h30);
    ev_stop = 1'b1; tick();
  endtask

  task automatic t_flags();
    ev_gen_call = 1'b1; tick();
    chk("R10 gcall set", rd_data, 8'h12);
    ev_arb_lost = 1'b1; tick();
    chk("R10 arb set in slave", rd_data, 8'h1A);
    cpu_wr(8'h10);
    chk("R12 write cannot clear low flags", rd_data, 8'h1A);
    ev_stop = 1'b1; tick();
    chk("R10 stop clears gcall only", rd_data, 8'h18);
    ev_start = 1'b1; tick();
    chk("R10 start clears arb", rd_data, 8'h30);
    ev_stop = 1'b1; tick();
    wr_en = 1'b1; wr_data = 8'h10; ev_byte_done = 1'b1; tick();
    chk("R9 byte end beats cpu clear", rd_data, 8'h00);
    cpu_wr(8'h10);
    chk("R9 cleared again", rd_data, 8'h10);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mode_write();
    t_slave_load();
    t_arb_sequence();
    t_stop_priority();
    t_guard();
    t_flags();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule